// File: doc/BRIEF.md
# Vectored IRQ/FIQ Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt request lines and sorts each one into one of two CPU interrupt classes: the normal interrupt (IRQ) or the fast interrupt (FIQ). A per-source class bit makes the choice. A per-source enable bit decides whether a request may be serviced at all. A source is pending when its raw request is high and its enable bit is set. Among the pending sources of each class, the lowest source index wins. For the winner of each class the block presents an offset and a vector address, each in a read-only register.

Software programs the block through a simple register bus. The bus has a write strobe, an address and write data. Read data follows the address with no clock in between. A control bit selects how the vector address is formed. With vectored dispatch off, the vector register holds the class exception base: 0x18 for IRQ and 0x1C for FIQ. With it on, each source has its own fixed word entry past that base, so the handler can be reached without a software dispatch step.

Register map (byte addresses), with source n held at bit n%32 of word n/32:

- Class words at 0x0C, 0x10 and 0x14. A bit value of 1 sends the source to FIQ.
- Enable words at 0x18, 0x1C and 0x20.
- IRQ offset at 0x24 and FIQ offset at 0x28 (read-only).
- IRQ vector at 0x2C and FIQ vector at 0x30 (read-only).
- Control at 0x34. Bit 0 turns vectored dispatch on.

Top module: `vec_intc`

## Requirements
- R1: After reset every enable bit, every class bit and the control bit read 0. While reset is low again and no write has been made, neither irq_o nor fiq_o rises, whatever the requests.
- R2: A source whose enable bit is 0 never causes irq_o or fiq_o to rise. Once its enable bit is 1, a high request does cause it.
- R3: A pending source with class bit 0 drives irq_o and takes part only in the IRQ result. With class bit 1 it drives fiq_o and takes part only in the FIQ result.
- R4: Within each class, the pending source with the lowest index wins. The offset register of that class reads 4 times the winner's index.
- R5: When a class has no pending source, its output is low and its offset and vector registers both read 0.
- R6: With control bit 0 set to 1, the vector register of a class reads base + 0x20 + 4 × index, where base is 0x18 for IRQ and 0x1C for FIQ.
- R7: With control bit 0 cleared, the vector register of a class with a pending source reads its base: 0x18 for IRQ and 0x1C for FIQ.
- R8: A register write takes effect at the next rising clock edge and not before. Writes to read-only or unmapped addresses change nothing.
- R9: The outputs and result registers follow the request lines with no clock in between. When a request drops, the output of its class falls at once if no other source of that class is pending.
- R10: Class and enable bits for source indices at or above NSRC read 0, even after all-ones is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Level-sensitive interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| irq_o | output | 1 | Any pending IRQ-class source |
| fiq_o | output | 1 | Any pending FIQ-class source |

## Verification
Requests reach irq_o, fiq_o and the four result registers through logic only, with no register on the way. The bench therefore changes req_i away from the clock edge and samples these outputs half a nanosecond later, inside the same clock phase. A register write lands only at the next rising edge. The bench confirms that the old value still holds half a nanosecond before that edge and that the new value is visible half a nanosecond after it. Reads are combinational from addr, so each read is sampled a short settle time after the address changes, and no clock edge is involved.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] A_MODE0   = 8'h0C;
  localparam logic [7:0] A_MASK0   = 8'h18;
  localparam logic [7:0] A_IRQ_OFF = 8'h24;
  localparam logic [7:0] A_FIQ_OFF = 8'h28;
  localparam logic [7:0] A_IRQ_VEC = 8'h2C;
  localparam logic [7:0] A_FIQ_VEC = 8'h30;
  localparam logic [7:0] A_CTRL    = 8'h34;
  localparam int         MAP_WORDS = 3;

  localparam logic [31:0] IRQ_BASE = 32'h18;
  localparam logic [31:0] FIQ_BASE = 32'h1C;
  localparam logic [31:0] VEC_SKIP = 32'h20;

  typedef struct packed {
    logic        found;
    logic [31:0] off;
    logic [31:0] vec;
  } vic_result_t;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NSRC = 40,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [NSRC-1:0] mode_o,
  output logic [NSRC-1:0] mask_o,
  output logic            ven_o,
  output logic [31:0]     rd_o
);
  logic [NSRC-1:0] mode_q, mask_q;
  logic            ven_q;

  // Each source bit is written from its own word address.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      mask_q <= '0;
      ven_q  <= 1'b0;
    end else if (wr_en) begin
      for (int b = 0; b < NSRC; b++) begin
        if (addr == AW'(A_MODE0 + 8'(4 * (b / 32)))) mode_q[b] <= wdata[b[4:0]];
        if (addr == AW'(A_MASK0 + 8'(4 * (b / 32)))) mask_q[b] <= wdata[b[4:0]];
      end
      if (addr == AW'(A_CTRL)) ven_q <= wdata[0];
    end
  end

  always_comb begin
    rd_o = '0;
    for (int b = 0; b < NSRC; b++) begin
      if (addr == AW'(A_MODE0 + 8'(4 * (b / 32)))) rd_o[b[4:0]] = mode_q[b];
      if (addr == AW'(A_MASK0 + 8'(4 * (b / 32)))) rd_o[b[4:0]] = mask_q[b];
    end
    if (addr == AW'(A_CTRL)) rd_o[0] = ven_q;
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign ven_o  = ven_q;

  // R1: state is clear on the first cycle out of reset
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && mode_q == '0 && !ven_q));

  // R8: a write to enable word 0 lands at the next edge
  a_r8_mask_write_lands: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == AW'(A_MASK0)) |-> mask_q[0] == $past(wdata[0]));

  // R8: no write strobe leaves the state unchanged
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(mask_q) && $stable(mode_q) && $stable(ven_q)));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 40,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Fixed priority: the lowest index wins.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R4: the winner is pending and no lower index is
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (pend_i[idx_o] && ((pend_i & ~({N{1'b1}} << idx_o)) == '0)));
endmodule

// File: rtl/vic_vec.sv
module vic_vec
  import vic_pkg::*;
#(
  parameter int          IW   = 6,
  parameter logic [31:0] BASE = 32'h18
) (
  input  logic          found_i,
  input  logic [IW-1:0] idx_i,
  input  logic          ven_i,
  output vic_result_t   res_o
);
  logic [31:0] off;

  assign off = 32'(idx_i) << 2;

  always_comb begin
    res_o.found = found_i;
    res_o.off   = found_i ? off : '0;
    if (!found_i)   res_o.vec = '0;
    else if (ven_i) res_o.vec = BASE + VEC_SKIP + off;
    else            res_o.vec = BASE;
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NSRC = 40,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  initial begin
    if (NSRC > 32 * MAP_WORDS) $error("NSRC exceeds register map");
  end

  logic [NSRC-1:0] mode, mask;
  logic            ven;
  logic [31:0]     reg_rd;
  logic [NSRC-1:0] pend [2];
  vic_result_t     res  [2];

  vic_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_o(mode), .mask_o(mask), .ven_o(ven), .rd_o(reg_rd)
  );

  assign pend[0] = req_i & mask & ~mode;
  assign pend[1] = req_i & mask & mode;

  // One arbiter and vector builder per class: 0 = IRQ, 1 = FIQ.
  for (genvar c = 0; c < 2; c++) begin : g_class
    logic          found;
    logic [IW-1:0] idx;

    vic_prio #(.N(NSRC), .IW(IW)) u_prio (
      .clk(clk), .rst(rst), .pend_i(pend[c]), .found_o(found), .idx_o(idx)
    );

    vic_vec #(.IW(IW), .BASE((c == 0) ? IRQ_BASE : FIQ_BASE)) u_vec (
      .found_i(found), .idx_i(idx), .ven_i(ven), .res_o(res[c])
    );
  end

  assign irq_o = res[0].found;
  assign fiq_o = res[1].found;

  always_comb begin
    case (addr)
      AW'(A_IRQ_OFF): rdata = res[0].off;
      AW'(A_FIQ_OFF): rdata = res[1].off;
      AW'(A_IRQ_VEC): rdata = res[0].vec;
      AW'(A_FIQ_VEC): rdata = res[1].vec;
      default:        rdata = reg_rd;
    endcase
  end

  // R2: an output rises only for an enabled, requesting source of its class
  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> |(req_i & mask & ~mode));
  // R3: the fast output is only driven by sources routed to it
  a_r3_fiq_from_class: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> |(req_i & mask & mode));
  // R5: an idle class reads zero
  a_r5_idle_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (res[0].off == '0 && res[0].vec == '0));
  // R6: vectored dispatch layout for IRQ
  a_r6_irq_vec_layout: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ven) |-> res[0].vec == IRQ_BASE + VEC_SKIP + res[0].off);
  // R7: plain dispatch presents the FIQ base
  a_r7_fiq_base: assert property (@(posedge clk) disable iff (rst)
    (fiq_o && !ven) |-> res[1].vec == FIQ_BASE);
endmodule

// File: tb/vec_intc_test.sv
`timescale 1ns/100ps
module vec_intc_test;
  localparam int NSRC = 40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] req_i = '0;
  logic            wr_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq_o, fiq_o;

  int errors = 0;
  int checks = 0;

  logic [NSRC-1:0] sh_mode = '0, sh_mask = '0;
  logic            sh_ven = 1'b0;

  always #2 clk = ~clk;

  vec_intc #(.NSRC(NSRC), .AW(8)) uut (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Updates the shadow copy from the register map rules.
  task automatic shadow(input logic [7:0] a, input logic [31:0] d);
    for (int b = 0; b < NSRC; b++) begin
      if (a == 8'h0C + 8'(4 * (b / 32))) sh_mode[b] = d[b % 32];
      if (a == 8'h18 + 8'(4 * (b / 32))) sh_mask[b] = d[b % 32];
    end
    if (a == 8'h34) sh_ven = d[0];
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    shadow(a, d);
  endtask

  function automatic int winner(input logic [NSRC-1:0] p);
    for (int i = 0; i < NSRC; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_off(input int w);
    return (w < 0) ? 32'h0 : 32'(w) * 4;
  endfunction

  function automatic logic [31:0] exp_vec(input int w, input logic [31:0] base);
    if (w < 0) return 32'h0;
    return sh_ven ? base + 32'h20 + 32'(w) * 4 : base;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] d;
    int wi, wf;
    wi = winner(req_i & sh_mask & ~sh_mode);
    wf = winner(req_i & sh_mask & sh_mode);
    #0.5;
    chk({tag, " irq_o"}, 32'(irq_o), 32'(wi >= 0));
    chk({tag, " fiq_o"}, 32'(fiq_o), 32'(wf >= 0));
    rd(8'h24, d); chk({tag, " irq off"}, d, exp_off(wi));
    rd(8'h28, d); chk({tag, " fiq off"}, d, exp_off(wf));
    rd(8'h2C, d); chk({tag, " irq vec"}, d, exp_vec(wi, 32'h18));
    rd(8'h30, d); chk({tag, " fiq vec"}, d, exp_vec(wf, 32'h1C));
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(8'h18, d); chk("R1 mask0", d, 32'h0);
    rd(8'h1C, d); chk("R1 mask1", d, 32'h0);
    rd(8'h0C, d); chk("R1 mode0", d, 32'h0);
    rd(8'h34, d); chk("R1 ctrl", d, 32'h0);
    req_i = '1;
    #0.5;
    chk("R1 irq_o", 32'(irq_o), 32'h0);
    chk("R1 fiq_o", 32'(fiq_o), 32'h0);

    // R8: write lands at the next edge, not before
    @(negedge clk);
    req_i = 40'h1;
    addr = 8'h18; wdata = 32'h1; wr_en = 1'b1;
    #0.5;
    chk("R8 before edge", 32'(irq_o), 32'h0);
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
    chk("R8 after edge", 32'(irq_o), 32'h1);
    shadow(8'h18, 32'h1);

    // R2: disabled source ignored, enabled source seen
    wreg(8'h18, 32'hFFFF_FFDF);
    wreg(8'h1C, 32'hFF);
    req_i = 40'h20;
    check_all("R2 masked src5");
    wreg(8'h18, 32'hFFFF_FFFF);
    check_all("R2 enabled src5");

    // R3: class bit routes to FIQ
    wreg(8'h0C, 32'h20);
    check_all("R3 src5 fiq");
    chk("R3 irq low", 32'(irq_o), 32'h0);

    // R4: lowest index wins per class
    req_i = (40'h1 << 3) | (40'h1 << 7) | (40'h1 << 20) | (40'h1 << 35) | (40'h1 << 5);
    check_all("R4 mixed");
    rd(8'h24, d); chk("R4 irq off src3", d, 32'h0C);

    // R5: idle class reads zero
    req_i = '0;
    check_all("R5 idle");

    // R6: vectored dispatch
    wreg(8'h34, 32'h1);
    wreg(8'h10, 32'h80);
    req_i = (40'h1 << 3) | (40'h1 << 39);
    check_all("R6 vec on");
    rd(8'h2C, d); chk("R6 irq vec src3", d, 32'h44);
    rd(8'h30, d); chk("R6 fiq vec src39", d, 32'hD8);

    // R7: plain dispatch gives the base
    wreg(8'h34, 32'h0);
    check_all("R7 vec off");
    rd(8'h30, d); chk("R7 fiq base", d, 32'h1C);

    // R8: read-only and unmapped writes change nothing
    wreg(8'h24, 32'hFFFF);
    wreg(8'h40, 32'hFFFF_FFFF);
    sh_mask = sh_mask; // no shadow effect expected
    rd(8'h18, d); chk("R8 mask0 kept", d, sh_mask[31:0]);
    rd(8'h0C, d); chk("R8 mode0 kept", d, sh_mode[31:0]);
    check_all("R8 ro write");

    // R10: bits above NSRC read zero
    wreg(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R10 mask1 width", d, 32'hFF);
    wreg(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R10 mode2 empty", d, 32'h0);

    // R9: request drop is seen at once
    @(negedge clk);
    req_i = 40'h1 << 3;
    #0.5;
    chk("R9 irq up", 32'(irq_o), 32'h1);
    req_i = '0;
    #0.5;
    chk("R9 irq drop", 32'(irq_o), 32'h0);

    // R4: random traffic against the bench model
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 4) == 0) begin
        case ($urandom % 5)
          0: wreg(8'h0C, $urandom);
          1: wreg(8'h10, $urandom);
          2: wreg(8'h18, $urandom | $urandom);
          3: wreg(8'h1C, $urandom | $urandom);
          default: wreg(8'h34, $urandom);
        endcase
      end
      @(negedge clk);
      req_i = {$urandom & $urandom, $urandom & $urandom & $urandom} & {NSRC{1'b1}};
      check_all("R4 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule